// File: doc/BRIEF.md
# Inbound PCI Window Address Translator

This block sits on the bus-master path of a PCI host bridge. It maps addresses issued by PCI masters onto local memory through three programmable inbound windows. Each window has a 64-bit size-and-enable word and a 64-bit local base address. Software loads both through a 32-bit register port, one 32-bit half at a time.

The block decodes combinationally. For the PCI address on its input it reports whether a window claims the address, which window it is, and the local address that results. Every window is based at PCI address zero. An address inside a window is translated by adding it to that window's local base. Window state is held in registers with a synchronous, active-low reset. The reset value leaves every window disabled.

Top module: `pci_inbound_xlate`

## Requirements
- R1: After reset, each size word reads as 0xFFFFFFFF_00000000 and each local base reads as zero. Every PCI address then gives win_miss=1, win_hit=0, win_idx=0 and local_addr=0.
- R2: Register byte offsets are as follows. Window 0: size low 0x98, size high 0xF8, base low 0x9C, base high 0xA0. Window 1: size low 0xA4, base low 0xA8, base high 0xAC. Window 2: size low 0xB0, size high 0xFC, base low 0xB4, base high 0xB8. A write with reg_we=1 at a rising edge replaces only the addressed 32-bit half. Each register reads back its stored value combinationally on reg_rdata.
- R3: A write to any other offset, including a misaligned one such as 0x99, changes no state. A read of such an offset returns zero.
- R4: Window 1 has no register for the upper half of its size word. That half stays at 0xFFFFFFFF, so window 1 can never be larger than 2^32 bytes.
- R5: Bit 0 of a size word enables the window. A window whose bit 0 is clear claims no address.
- R6: The window size is the 64-bit two's complement of the size word with bits 2:0 cleared. Bits 2:1 have no effect on the size. An enabled window claims a PCI address A when A is less than its size.
- R7: If the size word is zero once bits 2:0 are cleared, the enabled window covers the whole 64-bit space (size 2^64).
- R8: On a hit, local_addr equals the window's local base plus A, modulo 2^64.
- R9: When more than one enabled window claims A, the lowest-numbered one wins. win_idx carries its number in binary (0, 1 or 2). win_hit=1 and win_miss=0 whenever a window claims A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pci_addr | input | 64 | PCI bus-master address to translate |
| win_hit | output | 1 | Some enabled window claims pci_addr |
| win_miss | output | 1 | No window claims pci_addr |
| win_idx | output | 2 | Number of the winning window |
| local_addr | output | 64 | Translated local address, zero on a miss |

## Verification
A corrupted size half shows up at once on the translation outputs. The window boundary moves, so addresses just inside or just outside the window flip between hit and miss. The same corruption shows on reg_rdata as soon as that offset is addressed. A wrong base half appears as a wrong local_addr on the first hit in that window. A half-write that spills into the other half, or a stray decode of an unmapped offset, appears on the next readback of the neighbouring register. The bench probes every window at its first and last byte and one byte past its end, in overlapping and wrapping arrangements.

// File: rtl/pci_inbound_xlate.sv
module pci_inbound_xlate #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] pci_addr,
  output logic              win_hit,
  output logic              win_miss,
  output logic [1:0]        win_idx,
  output logic [ADDR_W-1:0] local_addr
);
  localparam int NWIN = 3;
  localparam int HW = ADDR_W / 2;
  localparam logic [ADDR_W-1:0] SZ_RST = {{HW{1'b1}}, {HW{1'b0}}};
  localparam logic [ADDR_W-1:0] LOW_MASK = ~{{(ADDR_W-3){1'b0}}, 3'b111};

  logic [ADDR_W-1:0] szw   [NWIN];
  logic [ADDR_W-1:0] lbase [NWIN];
  logic [NWIN-1:0]   in_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        szw[i]   <= SZ_RST;
        lbase[i] <= '0;
      end
    end else if (reg_we) begin
      case (reg_addr)
        8'h98: szw[0][HW-1:0]    <= reg_wdata;
        8'hF8: szw[0][ADDR_W-1:HW] <= reg_wdata;
        8'h9C: lbase[0][HW-1:0]  <= reg_wdata;
        8'hA0: lbase[0][ADDR_W-1:HW] <= reg_wdata;
        8'hA4: szw[1][HW-1:0]    <= reg_wdata;
        8'hA8: lbase[1][HW-1:0]  <= reg_wdata;
        8'hAC: lbase[1][ADDR_W-1:HW] <= reg_wdata;
        8'hB0: szw[2][HW-1:0]    <= reg_wdata;
        8'hFC: szw[2][ADDR_W-1:HW] <= reg_wdata;
        8'hB4: lbase[2][HW-1:0]  <= reg_wdata;
        8'hB8: lbase[2][ADDR_W-1:HW] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      8'h98:   reg_rdata = szw[0][HW-1:0];
      8'hF8:   reg_rdata = szw[0][ADDR_W-1:HW];
      8'h9C:   reg_rdata = lbase[0][HW-1:0];
      8'hA0:   reg_rdata = lbase[0][ADDR_W-1:HW];
      8'hA4:   reg_rdata = szw[1][HW-1:0];
      8'hA8:   reg_rdata = lbase[1][HW-1:0];
      8'hAC:   reg_rdata = lbase[1][ADDR_W-1:HW];
      8'hB0:   reg_rdata = szw[2][HW-1:0];
      8'hFC:   reg_rdata = szw[2][ADDR_W-1:HW];
      8'hB4:   reg_rdata = lbase[2][HW-1:0];
      8'hB8:   reg_rdata = lbase[2][ADDR_W-1:HW];
      default: reg_rdata = '0;
    endcase
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [ADDR_W:0] span;
    assign span = {1'b0, ~(szw[g] & LOW_MASK)} + {{ADDR_W{1'b0}}, 1'b1};
    assign in_win[g] = szw[g][0] && ({1'b0, pci_addr} < span);
  end

  logic [ADDR_W-1:0] sel_base;
  always_comb begin
    win_idx  = 2'd0;
    sel_base = '0;
    if (in_win[0]) begin
      win_idx = 2'd0; sel_base = lbase[0];
    end else if (in_win[1]) begin
      win_idx = 2'd1; sel_base = lbase[1];
    end else if (in_win[2]) begin
      win_idx = 2'd2; sel_base = lbase[2];
    end
  end

  assign win_hit    = |in_win;
  assign win_miss   = ~win_hit;
  assign local_addr = win_hit ? sel_base + pci_addr : '0;

  // R1: windows come out of reset disabled
  a_r1_reset_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (win_miss && local_addr == '0));

  // R2: a low-half write leaves the high half of window 0 size untouched
  a_r2_half_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 8'h98) |=> szw[0][ADDR_W-1:HW] == $past(szw[0][ADDR_W-1:HW]));

  // R2: written value reads back
  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 8'h9C) |=> (reg_addr != 8'h9C || reg_rdata == $past(reg_wdata)));

  // R5: a reported window is always enabled
  a_r5_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> szw[win_idx][0]);

  // R9: a higher window only wins when window 0 does not claim the address
  a_r9_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && win_idx != 2'd0) |-> !in_win[0]);

  // R8: translated address minus base gives back the PCI address
  a_r8_offset: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (local_addr - lbase[win_idx]) == pci_addr);
endmodule

// File: tb/pci_inbound_xlate_tb.sv
module pci_inbound_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] pci_addr = '0;
  logic        win_hit, win_miss;
  logic [1:0]  win_idx;
  logic [63:0] local_addr;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pci_inbound_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pci_addr(pci_addr),
    .win_hit(win_hit), .win_miss(win_miss), .win_idx(win_idx),
    .local_addr(local_addr)
  );

  // addr, hit, idx, local
  localparam logic [130:0] VEC [7] = '{
    {64'h0000_0000_0000_0000, 1'b1, 2'd0, 64'h0000_0001_0000_0000},
    {64'h0000_0000_0000_FFFF, 1'b1, 2'd0, 64'h0000_0001_0000_FFFF},
    {64'h0000_0000_0000_0FFF, 1'b1, 2'd0, 64'h0000_0001_0000_0FFF},
    {64'h0000_0000_0001_0000, 1'b1, 2'd2, 64'hFFFF_FFFF_F001_0000},
    {64'h0000_0000_1234_5678, 1'b1, 2'd2, 64'h0000_0000_0234_5678},
    {64'h0000_0000_FFFF_FFFF, 1'b1, 2'd2, 64'h0000_0000_EFFF_FFFF},
    {64'h0000_0001_0000_0000, 1'b0, 2'd0, 64'h0000_0000_0000_0000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, {32'd0, reg_rdata}, {32'd0, exp});
  endtask

  task automatic xl(input string tag, input logic [63:0] a, input logic h,
                    input logic [1:0] idx, input logic [63:0] la);
    @(negedge clk);
    pci_addr = a;
    #1;
    chk(tag, {61'd0, win_hit, win_idx}, {61'd0, h, (h ? idx : 2'd0)});
    chk(tag, {63'd0, win_miss}, {63'd0, ~h});
    chk(tag, local_addr, h ? la : 64'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 w0 size lo", 8'h98, 32'h0);
    rd("R1 w0 size hi", 8'hF8, 32'hFFFF_FFFF);
    rd("R1 w1 size lo", 8'hA4, 32'h0);
    rd("R1 w2 size hi", 8'hFC, 32'hFFFF_FFFF);
    rd("R1 w2 base hi", 8'hB8, 32'h0);
    xl("R1 miss after reset", 64'h0, 1'b0, 2'd0, 64'h0);

    // R2 half writes and readback
    wr(8'hA0, 32'h0000_0001);
    wr(8'h9C, 32'h0000_0000);
    rd("R2 base hi kept", 8'hA0, 32'h0000_0001);
    rd("R2 base lo", 8'h9C, 32'h0);
    wr(8'h98, 32'hFFFF_0001);
    rd("R2 size hi kept", 8'hF8, 32'hFFFF_FFFF);
    rd("R2 size lo", 8'h98, 32'hFFFF_0001);
    // R6: bits 2:1 set but ignored -> size 0x1000
    wr(8'hA4, 32'hFFFF_F007);
    wr(8'hA8, 32'h2000_0000);
    rd("R2 w1 base lo", 8'hA8, 32'h2000_0000);
    wr(8'hB4, 32'hF000_0000);
    wr(8'hB8, 32'hFFFF_FFFF);
    wr(8'hB0, 32'h0000_0001);
    rd("R2 w2 size lo", 8'hB0, 32'h1);

    // table: R6 boundaries, R8 wrap, R9 overlap
    for (int i = 0; i < 7; i++) begin
      xl("R6/R8/R9 vector", VEC[i][130:67], VEC[i][66], VEC[i][65:64], VEC[i][63:0]);
    end

    // R5: disable window 0, window 1 now wins at low addresses
    wr(8'h98, 32'hFFFF_0000);
    xl("R5 w0 disabled", 64'h0, 1'b1, 2'd1, 64'h2000_0000);
    xl("R6 w1 last byte bits2:1 ignored", 64'hFFF, 1'b1, 2'd1, 64'h2000_0FFF);
    xl("R6 w1 past end", 64'h1000, 1'b1, 2'd2, 64'hFFFF_FFFF_F000_1000);

    // R3: unmapped and misaligned writes ignored
    wr(8'hF4, 32'hDEAD_BEEF);
    wr(8'h99, 32'h0000_0001);
    rd("R3 unmapped reads zero", 8'hF4, 32'h0);
    rd("R3 misaligned no effect", 8'h98, 32'hFFFF_0000);
    xl("R3 w0 still disabled", 64'h0, 1'b1, 2'd1, 64'h2000_0000);

    // R4: window 1 limited to 4 GiB
    wr(8'hB0, 32'h0);
    wr(8'hA4, 32'h0000_0001);
    xl("R4 w1 4GiB last byte", 64'hFFFF_FFFF, 1'b1, 2'd1, 64'h1_1FFF_FFFF);
    xl("R4 w1 4GiB past end", 64'h1_0000_0000, 1'b0, 2'd0, 64'h0);
    rd("R4 no w1 size hi reg", 8'hF4, 32'h0);

    // R7: zero masked size word covers all of the space
    wr(8'hA4, 32'h0);
    wr(8'hFC, 32'h0);
    wr(8'hB0, 32'h0000_0007);
    xl("R7 full space top", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd2, 64'hFFFF_FFFF_EFFF_FFFF);
    xl("R7 full space zero", 64'h0, 1'b1, 2'd2, 64'hFFFF_FFFF_F000_0000);

    // R1: reset again restores disabled state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    xl("R1 miss after second reset", 64'h0, 1'b0, 2'd0, 64'h0);
    rd("R1 w2 size hi restored", 8'hFC, 32'hFFFF_FFFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule